// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of transmit descriptors kept in system memory and turns each one into a byte stream for a MAC transmitter. Software loads the ring base, fills in descriptors and hands each one over by setting its ownership flag. It then writes the poll-demand register to wake the engine. For every owned descriptor, the engine reads the buffer pointer and the byte count. It streams the bytes with frame-boundary markers and writes the control word back with ownership returned to software. It then moves on to the next descriptor without being polled again.

Each descriptor is four 32-bit words aligned to 16 bytes. Word 0 is the control word, word 3 is the buffer pointer, and the hardware never touches the other two. A descriptor flagged as the last in the ring sends the engine back to the base. When the engine reaches a descriptor that software has not handed over, it goes idle and stays on that slot. Short frames are not padded, and CRC generation is left to the transmitter downstream.

Top module: `tdr_engine`

## Requirements
- R1: After reset the engine is idle: `mem_req_o`, `tx_valid_o` and `tx_done_o` are low, and it stays idle until polled.
- R2: A register write at offset 0x20 sets the ring base, with address bits 3:0 forced to zero. While the engine is idle, the same write also moves the current descriptor pointer to that base. A write of any value at offset 0x18 makes an idle engine read word 0 of the current descriptor. Writes at any other offset start no memory access.
- R3: If bit 31 (ownership) of the fetched word 0 is clear, the engine emits no byte, writes nothing back, and keeps its pointer, so the next poll reads the same descriptor address.
- R4: For an owned descriptor, the engine reads word 3 (descriptor address + 12) as the buffer byte address. It then streams word 0 bits 13:0 bytes in ascending address order. Within a memory word, the byte at address offset k is bits 8k+7:8k. The buffer address need not be word aligned.
- R5: `tx_sof_o` is high on the first byte of a descriptor if and only if word 0 bit 29 is set. `tx_eof_o` is high on the last byte if and only if word 0 bit 28 is set. Both are low on every other byte.
- R6: After the last byte, the engine writes word 0 back to the descriptor address with bit 31 cleared and every other bit, end-of-ring bit 15 included, unchanged.
- R7: `tx_done_o` pulses for one cycle right after each write-back is acknowledged. The engine then fetches the next descriptor at pointer + 16 without a new poll.
- R8: After a descriptor with word 0 bit 15 set, the next descriptor is fetched from the ring base.
- R9: A descriptor with byte count zero produces no byte but is still written back and still raises `tx_done_o`.
- R10: Every memory access is word aligned. `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay steady until the cycle in which `mem_ack_i` is high.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the byte and its markers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Byte available |
| tx_data_o | output | 8 | Byte value |
| tx_sof_o | output | 1 | First byte of a frame |
| tx_eof_o | output | 1 | Last byte of a frame |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| tx_done_o | output | 1 | One-cycle pulse per completed descriptor |

## Verification
On every cycle, the assertions check that the memory and stream handshakes hold steady, that accesses stay word aligned, that a write-back never carries ownership, and that each completion pulse follows an acknowledged write. Only the bench's scenarios can show the rest. Those cover byte order from an unaligned buffer, the frame markers taken from the control word, preservation of the other control bits, idling on a descriptor software still owns, continuing through the ring without a poll, wrapping at the end-of-ring flag, and a zero-length descriptor.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned OWN_BIT   = 31;
  localparam int unsigned FIRST_BIT = 29;
  localparam int unsigned LAST_BIT  = 28;
  localparam int unsigned EOR_BIT   = 15;
  localparam int unsigned LEN_W     = 14;
  localparam int unsigned DESC_SZ   = 16;  // bytes per descriptor
  localparam int unsigned BUF_OFS   = 12;  // byte offset of buffer pointer word
  localparam int unsigned POLL_OFS  = 'h18;
  localparam int unsigned BASE_OFS  = 'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTRL,
    ST_RD_BUF,
    ST_RD_DATA,
    ST_STREAM,
    ST_WR_BACK
  } tdr_state_e;
endpackage

// File: rtl/tdr_regs.sv
module tdr_regs #(
  parameter int unsigned AW     = 32,
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [AW-1:0]     base_o,
  output logic [AW-1:0]     base_nxt_o,
  output logic              base_wr_o,
  output logic              poll_o
);
  import tdr_pkg::*;

  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_SZ - 1);

  logic [AW-1:0] base_q;

  assign base_wr_o  = reg_we_i && (reg_addr_i == REG_AW'(BASE_OFS));
  assign poll_o     = reg_we_i && (reg_addr_i == REG_AW'(POLL_OFS));
  assign base_nxt_o = reg_wdata_i[AW-1:0] & ALIGN_MASK;
  assign base_o     = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_wr_o) base_q <= base_nxt_o;
  end
endmodule

// File: rtl/tdr_unpack.sv
module tdr_unpack #(
  parameter int unsigned DW = 32,
  localparam int unsigned LANES = DW / 8,
  localparam int unsigned SELW  = $clog2(LANES)
) (
  input  logic [DW-1:0]   word_i,
  input  logic [SELW-1:0] sel_i,
  output logic [7:0]      byte_o
);
  logic [7:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  assign byte_o = lane[sel_i];
endmodule

// File: rtl/tdr_ctrl.sv
module tdr_ctrl #(
  parameter int unsigned AW = 32,
  localparam int unsigned DW   = tdr_pkg::DW,
  localparam int unsigned SELW = $clog2(DW / 8),
  localparam int unsigned LW   = tdr_pkg::LEN_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   base_nxt_i,
  input  logic            base_wr_i,
  input  logic            poll_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   word_o,
  output logic [SELW-1:0] sel_o,
  output logic            tx_valid_o,
  output logic            tx_sof_o,
  output logic            tx_eof_o,
  input  logic            tx_ready_i,
  output logic            done_o
);
  import tdr_pkg::*;

  tdr_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] cur_q;
  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] word_q;
  logic [LW-1:0] remain_q;
  logic          first_q;
  logic          done_q;

  logic          last_byte;
  logic [AW-1:0] ptr_next;

  assign last_byte = (remain_q == LW'(1));
  assign ptr_next  = ctrl_q[EOR_BIT] ? base_i : ptr_q + AW'(DESC_SZ);

  always_comb begin
    mem_req_o  = 1'b1;
    mem_we_o   = 1'b0;
    mem_addr_o = ptr_q;
    unique case (state_q)
      ST_RD_CTRL: mem_addr_o = ptr_q;
      ST_RD_BUF:  mem_addr_o = ptr_q + AW'(BUF_OFS);
      ST_RD_DATA: mem_addr_o = {cur_q[AW-1:SELW], SELW'(0)};
      ST_WR_BACK: mem_we_o   = 1'b1;
      default:    mem_req_o  = 1'b0;
    endcase
  end

  assign mem_wdata_o = ctrl_q & ~(DW'(1) << OWN_BIT);
  assign word_o      = word_q;
  assign sel_o       = cur_q[SELW-1:0];
  assign tx_valid_o  = (state_q == ST_STREAM);
  assign tx_sof_o    = tx_valid_o && first_q && ctrl_q[FIRST_BIT];
  assign tx_eof_o    = tx_valid_o && last_byte && ctrl_q[LAST_BIT];
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      cur_q    <= '0;
      ctrl_q   <= '0;
      word_q   <= '0;
      remain_q <= '0;
      first_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (base_wr_i)   ptr_q   <= base_nxt_i;
          else if (poll_i) state_q <= ST_RD_CTRL;
        end
        ST_RD_CTRL: if (mem_ack_i) begin
          ctrl_q  <= mem_rdata_i;
          state_q <= mem_rdata_i[OWN_BIT] ? ST_RD_BUF : ST_IDLE;
        end
        ST_RD_BUF: if (mem_ack_i) begin
          cur_q    <= mem_rdata_i[AW-1:0];
          remain_q <= ctrl_q[LW-1:0];
          first_q  <= 1'b1;
          state_q  <= (ctrl_q[LW-1:0] == '0) ? ST_WR_BACK : ST_RD_DATA;
        end
        ST_RD_DATA: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          state_q <= ST_STREAM;
        end
        ST_STREAM: if (tx_ready_i) begin
          cur_q    <= cur_q + AW'(1);
          remain_q <= remain_q - LW'(1);
          first_q  <= 1'b0;
          if (last_byte)              state_q <= ST_WR_BACK;
          else if (&cur_q[SELW-1:0])  state_q <= ST_RD_DATA;
        end
        ST_WR_BACK: if (mem_ack_i) begin
          done_q  <= 1'b1;
          ptr_q   <= ptr_next;
          state_q <= ST_RD_CTRL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tdr_engine.sv
module tdr_engine #(
  parameter int unsigned AW     = 32,
  parameter int unsigned REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_eof_o,
  input  logic              tx_ready_i,
  output logic              tx_done_o
);
  localparam int unsigned SELW = $clog2(tdr_pkg::DW / 8);

  logic [AW-1:0]   base;
  logic [AW-1:0]   base_nxt;
  logic            base_wr;
  logic            poll;
  logic [31:0]     word;
  logic [SELW-1:0] sel;

  tdr_regs #(.AW(AW), .REG_AW(REG_AW)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .base_o      (base),
    .base_nxt_o  (base_nxt),
    .base_wr_o   (base_wr),
    .poll_o      (poll)
  );

  tdr_ctrl #(.AW(AW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (base),
    .base_nxt_i  (base_nxt),
    .base_wr_i   (base_wr),
    .poll_i      (poll),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .word_o      (word),
    .sel_o       (sel),
    .tx_valid_o  (tx_valid_o),
    .tx_sof_o    (tx_sof_o),
    .tx_eof_o    (tx_eof_o),
    .tx_ready_i  (tx_ready_i),
    .done_o      (tx_done_o)
  );

  tdr_unpack #(.DW(tdr_pkg::DW)) i_unpack (
    .word_i (word),
    .sel_i  (sel),
    .byte_o (tx_data_o)
  );
endmodule

// File: rtl/tdr_engine_chk.sv
module tdr_engine_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [31:0]   mem_wdata_o,
  input logic          mem_ack_i,
  input logic          tx_valid_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_sof_o,
  input logic          tx_eof_o,
  input logic          tx_ready_i,
  input logic          tx_done_o
);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
      && $stable(mem_wdata_o));

  a_r10_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  a_r6_wb_no_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);

  a_r11_byte_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_sof_o)
      && $stable(tx_eof_o));

  a_r7_done_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  a_r5_marks_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sof_o || tx_eof_o) |-> tx_valid_o);

  a_r4_no_byte_during_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_valid_o && mem_req_o));
endmodule

bind tdr_engine tdr_engine_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_tdr_engine.sv
module test_tdr_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        tx_valid_o, tx_sof_o, tx_eof_o, tx_done_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int n_acc = 0;
  int n_bytes = 0;
  int n_done = 0;
  logic [31:0] last_addr = '0;
  bit ready_toggle = 1'b0;

  logic [31:0] mem [0:1023];
  logic [9:0]  exp_q [$];
  logic [63:0] wb_q [$];

  always #10 clk_i = ~clk_i;

  tdr_engine i_tdr_engine (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit own, input bit first, input bit last,
                                          input bit eor, input int len, input logic [31:0] extra);
    return extra | (32'(own) << 31) | (32'(first) << 29) | (32'(last) << 28)
         | (32'(eor) << 15) | 32'(len & 16'h3FFF);
  endfunction

  task automatic set_desc(input logic [31:0] a, input logic [31:0] ctrl, input logic [31:0] buf_a);
    mem[a[11:2]]     = ctrl;
    mem[a[11:2] + 1] = 32'h0;
    mem[a[11:2] + 2] = 32'hDEAD_BEEF;
    mem[a[11:2] + 3] = buf_a;
  endtask

  // expected bytes and write-back for one owned descriptor
  task automatic expect_desc(input logic [31:0] a, input logic [31:0] ctrl, input logic [31:0] buf_a);
    int len = int'(ctrl[13:0]);
    for (int i = 0; i < len; i++)
      exp_q.push_back({ctrl[28] && (i == len - 1), ctrl[29] && (i == 0), pat(buf_a + 32'(i))});
    wb_q.push_back({a, ctrl & 32'h7FFF_FFFF});
  endtask

  task automatic reg_write(input logic [7:0] ofs, input logic [31:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = ofs; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic wait_quiet();
    while (exp_q.size() != 0 || wb_q.size() != 0) @(posedge clk_i);
    repeat (30) @(posedge clk_i);
  endtask

  // memory model: ack one cycle after request is seen, performs access then
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        n_acc++;
        last_addr = mem_addr_o;
        if (mem_addr_o[1:0] != 2'b00) check("R10 aligned", 64'(mem_addr_o[1:0]), 64'h0);
        if (mem_we_o) begin
          mem[mem_addr_o[11:2]] = mem_wdata_o;
          if (wb_q.size() == 0) check("R6 unexpected write-back", {mem_addr_o, mem_wdata_o}, 64'h0);
          else check("R6 write-back", {mem_addr_o, mem_wdata_o}, wb_q.pop_front());
        end else begin
          mem_rdata_i = mem[mem_addr_o[11:2]];
        end
        mem_ack_i = 1'b1;
      end
    end
  end

  // stream monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk_i);
      if (tx_done_o) n_done++;
      if (tx_valid_o && tx_ready_i) begin
        n_bytes++;
        if (exp_q.size() == 0) check("R4 unexpected byte", 64'({tx_eof_o, tx_sof_o, tx_data_o}), 64'h3FF);
        else check("R4 R5 byte", 64'({tx_eof_o, tx_sof_o, tx_data_o}), 64'(exp_q.pop_front()));
      end
    end
  end

  // ready driver, stall pattern for R11
  initial begin
    int k = 0;
    forever begin
      @(posedge clk_i); #1;
      k++;
      tx_ready_i = ready_toggle ? (k % 3 != 0) : 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c0, c1, c2, c3;
    for (int i = 0; i < 1024; i++) mem[i] = {pat(32'(4*i+3)), pat(32'(4*i+2)), pat(32'(4*i+1)), pat(32'(4*i))};
    set_desc(32'h100, mk_ctrl(0, 1, 1, 0, 6, 0), 32'h400);
    set_desc(32'h110, mk_ctrl(0, 0, 0, 0, 0, 0), 32'h0);
    set_desc(32'h120, mk_ctrl(0, 0, 0, 1, 0, 0), 32'h0);

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 req", 64'(mem_req_o), 64'h0);
    check("R1 valid", 64'(tx_valid_o), 64'h0);
    check("R1 done", 64'(tx_done_o), 64'h0);
    repeat (10) @(posedge clk_i);
    check("R1 stays idle", 64'(n_acc), 64'h0);

    // R2: write at an unrelated offset starts nothing
    reg_write(8'h1C, 32'hFFFF_FFFF);
    repeat (20) @(posedge clk_i);
    check("R2 other offset", 64'(n_acc), 64'h0);

    // R2 base with low bits ignored, R3 unowned descriptor
    reg_write(8'h20, 32'h0000_010F);
    reg_write(8'h18, 32'h0);
    repeat (20) @(posedge clk_i);
    check("R2 R3 one access", 64'(n_acc), 64'h1);
    check("R2 base aligned", 64'(last_addr), 64'h100);
    check("R3 no bytes", 64'(n_bytes), 64'h0);
    check("R3 no done", 64'(n_done), 64'h0);

    // R3 pointer kept: same slot now owned
    c0 = mk_ctrl(1, 1, 1, 0, 6, 0);
    set_desc(32'h100, c0, 32'h400);
    expect_desc(32'h100, c0, 32'h400);
    n_acc = 0;
    reg_write(8'h18, 32'h1234);
    wait_quiet();
    check("R4 byte count", 64'(n_bytes), 64'h6);
    check("R7 one done", 64'(n_done), 64'h1);
    check("R7 next slot probed", 64'(last_addr), 64'h110);
    check("R3 R4 access count", 64'(n_acc), 64'h6);

    // R7 chain without poll, R8 wrap, R9 zero length, R11 stalls
    ready_toggle = 1'b1;
    c1 = mk_ctrl(1, 1, 0, 0, 5, 0);
    c2 = mk_ctrl(1, 0, 1, 1, 3, 32'h0008_0000);
    c3 = mk_ctrl(1, 1, 1, 0, 0, 32'h0000_4000);
    set_desc(32'h110, c1, 32'h503);
    set_desc(32'h120, c2, 32'h5FE);
    set_desc(32'h100, c3, 32'h0);
    expect_desc(32'h110, c1, 32'h503);
    expect_desc(32'h120, c2, 32'h5FE);
    expect_desc(32'h100, c3, 32'h0);
    reg_write(8'h18, 32'h0);
    wait_quiet();
    check("R4 R9 total bytes", 64'(n_bytes), 64'd14);
    check("R7 R9 done pulses", 64'(n_done), 64'h4);
    check("R8 wrapped then probed", 64'(last_addr), 64'h110);
    check("R6 eor kept in memory", 64'(mem[32'h120 >> 2]), 64'(c2 & 32'h7FFF_FFFF));
    check("R9 zero-length written back", 64'(mem[32'h100 >> 2]), 64'(c3 & 32'h7FFF_FFFF));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule